// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in. It has no clock. Every output is a combinational function of the current inputs.

The operands are split into four 4-bit groups. Each bit position forms a generate term, the AND of its operand bits. It also forms a propagate term, the OR of its operand bits. Each group condenses its four bit terms into a group generate and a group propagate. A second lookahead level then computes the carry into every group at once from those group terms and the incoming carry. No carry ripples from one group to the next. Inside each group, every internal carry is also written in flattened sum-of-products form. Each sum bit is the XOR of the two operand bits and the carry into that position.

The whole-adder generate and propagate are also brought out. A wider adder could place this block under a third lookahead level.

The adder sits in a datapath as plain combinational logic. There is no handshake at its edge, so back-pressure does not arise. Consumers register the outputs wherever their timing allows.

Top module: `cla_two_level_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `c0_i`) modulo 65536 for every input combination.
- R2: `c_out_o` equals bit 16 of the 17-bit result of `a_i` + `b_i` + `c0_i`.
- R3: `grp_prop_o` is 1 exactly when every bit position has at least one operand bit set, that is when (`a_i` | `b_i`) is 16'hFFFF.
- R4: `grp_gen_o` is 1 exactly when `a_i` + `b_i` overflows 16 bits with the carry-in taken as 0.
- R5: `c_out_o` always equals `grp_gen_o` | (`grp_prop_o` & `c0_i`).
- R6: A carry that enters at bit 0 and passes through all 16 positions is resolved correctly. For example, 16'hFFFF + 16'h0000 with `c0_i`=1 gives `sum_o`=0 and `c_out_o`=1.
- R7: A carry leaving the top bit of one 4-bit group (bits 3, 7 or 11) reaches the lowest bit of the next group. For example, 16'h000F + 16'h0001 gives 16'h0010.
- R8: The outputs follow the inputs with no clock edge and hold no state. All-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c0_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_out_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Generate term of the whole adder |
| grp_prop_o | output | 1 | Propagate term of the whole adder |

## Verification
The bench builds the adder with its defaults: four-bit groups, four groups, and a two-level carry tree. With four-bit groups, an exhaustive sweep of one group's operands and carry-in is only 512 vectors. That sweep is run in place on each group's bit slice, with the neighbouring groups forced to propagate. This drives every group-internal carry pattern and every lookahead input pattern. Directed vectors then cover the full 16-bit carry chain and the three group boundaries. Random 16-bit operands cover mixed generate and propagate patterns across all four groups.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned LA_MAX = 32;

  // Flattened lookahead: carry out of position n-1, given generate/propagate
  // terms for positions 0..n-1 and an incoming carry. Each product term is
  // formed independently, so no term depends on another carry.
  function automatic logic la_carry(
    input logic [LA_MAX-1:0] gen,
    input logic [LA_MAX-1:0] prop,
    input logic              cin,
    input int unsigned       n
  );
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int unsigned j = 0; j < LA_MAX; j++) begin
      if (j < n) begin
        prod = gen[j];
        for (int unsigned m = 0; m < LA_MAX; m++) begin
          if (m > j && m < n) prod = prod & prop[m];
        end
        acc = acc | prod;
      end
    end
    prod = cin;
    for (int unsigned m = 0; m < LA_MAX; m++) begin
      if (m < n) prod = prod & prop[m];
    end
    return acc | prod;
  endfunction

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic prop_o,
  output logic half_o
);
  assign gen_o  = a_i & b_i;
  assign prop_o = a_i | b_i;
  assign half_o = a_i ^ b_i;
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a_i,
  input  logic [GROUP_W-1:0] b_i,
  input  logic               cin_i,
  output logic [GROUP_W-1:0] sum_o,
  output logic               cout_o,
  output logic               ggen_o,
  output logic               gprop_o
);
  import cla_pkg::*;

  logic [GROUP_W-1:0] gen;
  logic [GROUP_W-1:0] prop;
  logic [GROUP_W-1:0] half;
  logic [GROUP_W:0]   carry;

  for (genvar i = 0; i < GROUP_W; i++) begin : g_bit
    cla_bit_gp u_gp (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .gen_o (gen[i]),
      .prop_o(prop[i]),
      .half_o(half[i])
    );
  end

  // Every internal carry is flattened: it comes from the bit terms and cin
  // directly, not from the carry of the previous position.
  always_comb begin
    carry[0] = cin_i;
    for (int unsigned k = 1; k <= GROUP_W; k++) begin
      carry[k] = la_carry(LA_MAX'(gen), LA_MAX'(prop), cin_i, k);
    end
  end

  assign sum_o   = half ^ carry[GROUP_W-1:0];
  assign cout_o  = carry[GROUP_W];
  assign ggen_o  = la_carry(LA_MAX'(gen), LA_MAX'(prop), 1'b0, GROUP_W);
  assign gprop_o = &prop;

  always_comb begin
    // R5
    grp_cout_chk: assert (cout_o == (ggen_o | (gprop_o & cin_i)))
      else $error("group carry out disagrees with group G/P");
    // R1
    grp_sum_chk: assert ({cout_o, sum_o} ==
                         ({1'b0, a_i} + {1'b0, b_i} + {{GROUP_W{1'b0}}, cin_i}))
      else $error("group sum mismatch");
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic [NUM_GROUPS-1:0] ggen_i,
  input  logic [NUM_GROUPS-1:0] gprop_i,
  input  logic                  c0_i,
  output logic [NUM_GROUPS:0]   gcarry_o,
  output logic                  tgen_o,
  output logic                  tprop_o
);
  import cla_pkg::*;

  always_comb begin
    gcarry_o[0] = c0_i;
    for (int unsigned k = 1; k <= NUM_GROUPS; k++) begin
      gcarry_o[k] = la_carry(LA_MAX'(ggen_i), LA_MAX'(gprop_i), c0_i, k);
    end
  end

  assign tgen_o  = la_carry(LA_MAX'(ggen_i), LA_MAX'(gprop_i), 1'b0, NUM_GROUPS);
  assign tprop_o = &gprop_i;

  always_comb begin
    for (int unsigned k = 0; k < NUM_GROUPS; k++) begin
      // R7
      la_ripple_equiv_chk: assert (gcarry_o[k+1] ==
                                   (ggen_i[k] | (gprop_i[k] & gcarry_o[k])))
        else $error("flattened group carry %0d differs from ripple form", k + 1);
    end
    // R4
    la_gen_chk: assert (!tgen_o || gcarry_o[NUM_GROUPS])
      else $error("whole-adder generate set without carry out");
  end
endmodule

// File: rtl/cla_two_level_adder.sv
module cla_two_level_adder #(
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_GROUPS = 4,
  localparam int unsigned DATA_W    = GROUP_W * NUM_GROUPS
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c0_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_out_o,
  output logic              grp_gen_o,
  output logic              grp_prop_o
);
  logic [NUM_GROUPS-1:0] ggen;
  logic [NUM_GROUPS-1:0] gprop;
  logic [NUM_GROUPS-1:0] gcout;
  logic [NUM_GROUPS:0]   gcarry;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    cla_group #(.GROUP_W(GROUP_W)) u_grp (
      .a_i    (a_i[k*GROUP_W +: GROUP_W]),
      .b_i    (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i  (gcarry[k]),
      .sum_o  (sum_o[k*GROUP_W +: GROUP_W]),
      .cout_o (gcout[k]),
      .ggen_o (ggen[k]),
      .gprop_o(gprop[k])
    );
  end

  cla_lookahead #(.NUM_GROUPS(NUM_GROUPS)) u_la (
    .ggen_i  (ggen),
    .gprop_i (gprop),
    .c0_i    (c0_i),
    .gcarry_o(gcarry),
    .tgen_o  (grp_gen_o),
    .tprop_o (grp_prop_o)
  );

  assign c_out_o = gcarry[NUM_GROUPS];

  always_comb begin
    for (int unsigned k = 0; k < NUM_GROUPS; k++) begin
      // R7
      grp_handoff_chk: assert (gcout[k] == gcarry[k+1])
        else $error("group %0d local carry differs from lookahead carry", k);
    end
    // R5
    top_cout_chk: assert (c_out_o == (grp_gen_o | (grp_prop_o & c0_i)))
      else $error("carry out disagrees with whole-adder G/P");
    // R2
    top_total_chk: assert ({c_out_o, sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c0_i}))
      else $error("adder total mismatch");
  end
endmodule

// File: tb/cla_two_level_adder_tb.sv
module cla_two_level_adder_tb;
  localparam int unsigned GW = 4;
  localparam int unsigned NG = 4;
  localparam int unsigned DW = GW * NG;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [DW-1:0] a, b, sum;
  logic          c0, cout, tg, tp;
  int            checks = 0;
  int            errors = 0;
  bit            done   = 1'b0;

  cla_two_level_adder #(.GROUP_W(GW), .NUM_GROUPS(NG)) u_dut (
    .a_i(a), .b_i(b), .c0_i(c0),
    .sum_o(sum), .c_out_o(cout), .grp_gen_o(tg), .grp_prop_o(tp)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [DW-1:0] x, input logic [DW-1:0] y, input logic c,
                       input string tag);
    logic [DW:0] full;
    logic [DW:0] nocin;
    @(negedge clk);
    a = x; b = y; c0 = c;
    #2;
    full  = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
    nocin = {1'b0, x} + {1'b0, y};
    cmp({tag, " R1 sum"},      32'(sum),  32'(full[DW-1:0]));
    cmp({tag, " R2 carry"},    32'(cout), 32'(full[DW]));
    cmp({tag, " R3 prop"},     32'(tp),   32'((x | y) == {DW{1'b1}}));
    cmp({tag, " R4 gen"},      32'(tg),   32'(nocin[DW]));
    cmp({tag, " R5 relation"}, 32'(cout), 32'(tg | (tp & c)));
  endtask

  task automatic t_idle();
    apply('0, '0, 1'b0, "R8 idle");
    cmp("R8 zero sum", 32'(sum), 32'd0);
    cmp("R8 zero carry", 32'(cout), 32'd0);
  endtask

  task automatic t_exhaustive_groups();
    logic [DW-1:0] fill_a, fill_b;
    for (int g = 0; g < int'(NG); g++) begin
      for (int x = 0; x < (1 << GW); x++) begin
        for (int y = 0; y < (1 << GW); y++) begin
          for (int c = 0; c < 2; c++) begin
            fill_a = {DW{1'b1}} & ~(DW'((1 << GW) - 1) << (g * GW));
            fill_b = '0;
            apply(fill_a | (DW'(x) << (g * GW)), fill_b | (DW'(y) << (g * GW)),
                  1'(c), "R1 exhaustive group");
          end
        end
      end
    end
  endtask

  task automatic t_long_chain();
    apply(16'hFFFF, 16'h0000, 1'b1, "R6 full chain cin");
    cmp("R6 chain sum zero", 32'(sum), 32'd0);
    cmp("R6 chain carry", 32'(cout), 32'd1);
    apply(16'hFFFF, 16'h0001, 1'b0, "R6 all ones plus one");
    apply(16'h7FFF, 16'h0001, 1'b0, "R6 chain to msb");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones both");
  endtask

  task automatic t_boundaries();
    apply(16'h000F, 16'h0001, 1'b0, "R7 boundary 3");
    cmp("R7 boundary 3 value", 32'(sum), 32'h0010);
    apply(16'h00F0, 16'h0010, 1'b0, "R7 boundary 7");
    cmp("R7 boundary 7 value", 32'(sum), 32'h0100);
    apply(16'h0F00, 16'h0100, 1'b0, "R7 boundary 11");
    cmp("R7 boundary 11 value", 32'(sum), 32'h1000);
    apply(16'h0FFF, 16'h0000, 1'b1, "R7 three groups");
  endtask

  task automatic t_random();
    for (int i = 0; i < 2000; i++) begin
      apply(DW'($urandom), DW'($urandom), 1'($urandom), "R1 random");
    end
  endtask

  initial begin
    a = '0; b = '0; c0 = 1'b0;
    t_idle();
    t_boundaries();
    t_long_chain();
    t_exhaustive_groups();
    t_random();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule